// File: doc/BRIEF.md
# Status Snapshot Serial Readout

This block freezes a group of status values into one 28-bit word and sends that word out one bit at a time on a serial data line. The word holds two input-port levels, a 20-bit counter value and four unlock flags. The word is captured once, when the host raises the output-select line. After that, changes at the sources do not reach the line. A host can therefore read a set of values that all belong to the same instant, even though the counter and the flags keep moving.

The block runs on a system clock. Both the output-select line and the serial clock are synchronised into that clock domain before edges are detected, and the number of synchroniser stages is a parameter. Each falling edge of the serial clock moves the word along by one bit. The host samples the line on the rising edge. While output is not selected, the line sits at logic 1.

Top module: `stat_snap_tx`

## Requirements
- R1: After reset, with output not selected, `sdo` is 1.
- R2: While `rd_sel` is low, `sdo` stays at 1 no matter how `sclk` and the source inputs move.
- R3: A rising edge on `rd_sel` captures the sources, and within `SYNC_STAGES`+2 clock cycles `sdo` shows the first bit of the captured word.
- R4: The bit order on `sdo`, first to last, is `port_in[0]`, `port_in[1]`, `cnt_val[19]` down to `cnt_val[0]`, `unlock[3]` down to `unlock[0]`, then two bits of 0.
- R5: Only a falling edge of `sclk` (1 to 0) while output is selected advances the line to the next bit. A rising edge leaves `sdo` unchanged.
- R6: Changes to `port_in`, `cnt_val` and `unlock` after the capture have no effect on the bits sent.
- R7: Once all 28 bits have been shifted out, further falling edges of `sclk` keep `sdo` at 0 until the next selection.
- R8: When `rd_sel` is lowered and raised again, the block captures the current source values and restarts the word from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset, asynchronous |
| rd_sel | input | 1 | Output-mode select. Its rising edge takes the snapshot |
| sclk | input | 1 | Serial clock from the host. Its falling edge shifts |
| port_in | input | 2 | Input-port levels. Bit 0 is sent first |
| cnt_val | input | 20 | Counter value to be captured |
| unlock | input | 4 | Unlock flags to be captured |
| sdo | output | 1 | Serial data out. Idles at 1 |

## Verification
If the capture register goes wrong, it shows up on the very first bit: `sdo` carries the wrong level a few system clocks after `rd_sel` rises. If it loses a shift or takes an extra one, every later bit of the word moves out of place, and a comparison against the expected word fails at the first field boundary after the fault. If the register is loaded from the live sources instead of being frozen, the error appears in the first bit sent after the sources change. If the idle forcing is broken, it is seen as soon as output is deselected.

// File: rtl/stat_snap_pkg.sv
package stat_snap_pkg;
   localparam int unsigned DEF_PORT_W  = 2;
   localparam int unsigned DEF_CNT_W   = 20;
   localparam int unsigned DEF_UL_W    = 4;
   localparam int unsigned DEF_FRAME_W = 28;
   localparam int unsigned DEF_SYNC    = 2;

   typedef enum logic {EDGE_RISE = 1'b0, EDGE_FALL = 1'b1} edge_kind_e;
endpackage

// File: rtl/stat_snap_sync.sv
module stat_snap_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [STAGES-1:0] chain_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain_q <= {STAGES{RST_VAL}};
            else if (STAGES == 1) chain_q <= d;
            else chain_q <= {chain_q[STAGES-2:0], d};
         end
         assign q = chain_q[STAGES-1];
      end
   endgenerate
endmodule

// File: rtl/stat_snap_edge.sv
module stat_snap_edge
   import stat_snap_pkg::*;
#(
   parameter edge_kind_e KIND    = EDGE_RISE,
   parameter logic       RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl,
   output logic hit
);
   logic prev_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RST_VAL;
      else prev_q <= lvl;
   end
   generate
      if (KIND == EDGE_RISE) begin : g_rise
         assign hit = lvl & ~prev_q;
      end else begin : g_fall
         assign hit = ~lvl & prev_q;
      end
   endgenerate
endmodule

// File: rtl/stat_snap_pack.sv
module stat_snap_pack #(
   parameter int unsigned PORT_W  = 2,
   parameter int unsigned CNT_W   = 20,
   parameter int unsigned UL_W    = 4,
   parameter int unsigned FRAME_W = 28
) (
   input  logic [PORT_W-1:0]  port_in,
   input  logic [CNT_W-1:0]   cnt_val,
   input  logic [UL_W-1:0]    unlock,
   output logic [FRAME_W-1:0] frame
);
   localparam int unsigned CNT_TOP = FRAME_W - 1 - PORT_W;
   localparam int unsigned UL_TOP  = CNT_TOP - CNT_W;
   localparam int unsigned PAD_W   = FRAME_W - PORT_W - CNT_W - UL_W;

   // port bit 0 leaves first, so it lands on the MSB
   for (genvar k = 0; k < PORT_W; k++) begin : g_port
      assign frame[FRAME_W-1-k] = port_in[k];
   end
   assign frame[CNT_TOP -: CNT_W] = cnt_val;
   assign frame[UL_TOP -: UL_W]   = unlock;
   generate
      if (PAD_W > 0) begin : g_pad
         assign frame[PAD_W-1:0] = '0;
      end
   endgenerate
endmodule

// File: rtl/stat_snap_shreg.sv
module stat_snap_shreg #(
   parameter int unsigned W = 28
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic         shift,
   input  logic [W-1:0] din,
   output logic [W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else if (load) q <= din;
      else if (shift) q <= {q[W-2:0], 1'b0};
   end
endmodule

// File: rtl/stat_snap_tx.sv
module stat_snap_tx
   import stat_snap_pkg::*;
#(
   parameter int unsigned PORT_W      = DEF_PORT_W,
   parameter int unsigned CNT_W       = DEF_CNT_W,
   parameter int unsigned UL_W        = DEF_UL_W,
   parameter int unsigned FRAME_W     = DEF_FRAME_W,
   parameter int unsigned SYNC_STAGES = DEF_SYNC
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rd_sel,
   input  logic              sclk,
   input  logic [PORT_W-1:0] port_in,
   input  logic [CNT_W-1:0]  cnt_val,
   input  logic [UL_W-1:0]   unlock,
   output logic              sdo
);
   localparam int unsigned USED_W = PORT_W + CNT_W + UL_W;

   generate
      if (USED_W > FRAME_W) begin : g_bad_w
         $error("stat_snap_tx: fields do not fit in FRAME_W");
      end
      if (FRAME_W < 2) begin : g_bad_f
         $error("stat_snap_tx: FRAME_W must be at least 2");
      end
   endgenerate

   logic sel_s, sclk_s, sel_rise, sclk_fall, active_q;
   logic [FRAME_W-1:0] frame, shreg;

   stat_snap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_sync_sel (
      .clk(clk), .rst_n(rst_n), .d(rd_sel), .q(sel_s));
   stat_snap_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync_sck (
      .clk(clk), .rst_n(rst_n), .d(sclk), .q(sclk_s));

   stat_snap_edge #(.KIND(EDGE_RISE), .RST_VAL(1'b0)) u_edge_sel (
      .clk(clk), .rst_n(rst_n), .lvl(sel_s), .hit(sel_rise));
   stat_snap_edge #(.KIND(EDGE_FALL), .RST_VAL(1'b1)) u_edge_sck (
      .clk(clk), .rst_n(rst_n), .lvl(sclk_s), .hit(sclk_fall));

   stat_snap_pack #(.PORT_W(PORT_W), .CNT_W(CNT_W), .UL_W(UL_W),
                    .FRAME_W(FRAME_W)) u_pack (
      .port_in(port_in), .cnt_val(cnt_val), .unlock(unlock), .frame(frame));

   stat_snap_shreg #(.W(FRAME_W)) u_shreg (
      .clk(clk), .rst_n(rst_n), .load(sel_rise),
      .shift(sclk_fall & active_q), .din(frame), .q(shreg));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) active_q <= 1'b0;
      else active_q <= sel_s;
   end

   assign sdo = active_q ? shreg[FRAME_W-1] : 1'b1;
endmodule

// File: rtl/stat_snap_chk.sv
module stat_snap_chk #(
   parameter int unsigned FW = 28
) (
   input logic          clk,
   input logic          rst_n,
   input logic          sel_s,
   input logic          sel_rise,
   input logic          sclk_fall,
   input logic          active_q,
   input logic [FW-1:0] frame,
   input logic [FW-1:0] shreg,
   input logic          sdo
);
   p_idle_high_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_s |=> sdo);

   p_capture_r3: assert property (@(posedge clk) disable iff (!rst_n)
      sel_rise |=> (shreg == $past(frame)));

   p_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (sclk_fall && active_q && !sel_rise) |=>
         (shreg == {$past(shreg[FW-2:0]), 1'b0}));

   p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!sclk_fall && !sel_rise) |=> $stable(shreg));

   p_first_bit_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (sel_rise && sel_s) |=> (sdo == $past(frame[FW-1])));
endmodule

bind stat_snap_tx stat_snap_chk #(.FW(FRAME_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .sel_s(sel_s), .sel_rise(sel_rise),
   .sclk_fall(sclk_fall), .active_q(active_q), .frame(frame),
   .shreg(shreg), .sdo(sdo));

// File: tb/stat_snap_tx_tb.sv
module stat_snap_tx_tb;
   localparam int CLK_PERIOD = 10;
   localparam int FW = 28;

   logic clk = 1'b0, rst_n = 1'b0, rd_sel = 1'b0, sclk = 1'b1;
   logic [1:0]  port_in = '0;
   logic [19:0] cnt_val = '0;
   logic [3:0]  unlock  = '0;
   logic        sdo;
   int total = 0, bad = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   stat_snap_tx u_dut (.clk(clk), .rst_n(rst_n), .rd_sel(rd_sel), .sclk(sclk),
      .port_in(port_in), .cnt_val(cnt_val), .unlock(unlock), .sdo(sdo));

   task automatic chk(input logic got, input logic exp, input string req);
      total++;
      if (got !== exp) begin
         bad++;
         $display("FAIL %s got=%0b exp=%0b", req, got, exp);
      end
   endtask

   task automatic wait_clk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic set_sel(input logic v);
      rd_sel = v; wait_clk(6);
   endtask

   task automatic sck_fall(); sclk = 1'b0; wait_clk(6); endtask
   task automatic sck_rise(); sclk = 1'b1; wait_clk(6); endtask

   function automatic logic [FW-1:0] expect_word(input logic [1:0] p,
      input logic [19:0] c, input logic [3:0] u);
      return {p[0], p[1], c, u, 2'b00};
   endfunction

   task automatic read_word(input logic [FW-1:0] exp, input string req);
      for (int i = 0; i < FW; i++) begin
         chk(sdo, exp[FW-1-i], req);
         sck_fall();
         sck_rise();
      end
   endtask

   task automatic t_reset();
      rst_n = 1'b0; wait_clk(3);
      chk(sdo, 1'b1, "R1 in reset");
      rst_n = 1'b1; wait_clk(4);
      chk(sdo, 1'b1, "R1 after reset");
   endtask

   task automatic t_idle();
      port_in = 2'b00; cnt_val = '0; unlock = '0;
      sck_fall(); chk(sdo, 1'b1, "R2 idle after fall");
      sck_rise(); chk(sdo, 1'b1, "R2 idle after rise");
      sck_fall(); sck_rise(); chk(sdo, 1'b1, "R2 idle zero sources");
   endtask

   task automatic t_order();
      logic [FW-1:0] e;
      port_in = 2'b01; cnt_val = 20'hA5C3F; unlock = 4'b1001;
      e = expect_word(port_in, cnt_val, unlock);
      set_sel(1'b1);
      chk(sdo, 1'b1, "R3 first bit is port_in[0]");
      read_word(e, "R4 order");
      chk(sdo, 1'b0, "R7 zero after word");
      sck_fall(); sck_rise();
      chk(sdo, 1'b0, "R7 still zero");
      set_sel(1'b0);
      chk(sdo, 1'b1, "R2 idle after deselect");
   endtask

   task automatic t_rise_only();
      port_in = 2'b10; cnt_val = 20'h00001; unlock = 4'b0110;
      set_sel(1'b1);
      chk(sdo, 1'b0, "R5 bit0 before edges");
      sck_rise();
      chk(sdo, 1'b0, "R5 rise does not shift");
      sck_fall();
      chk(sdo, 1'b1, "R5 fall shifts to port_in[1]");
      sck_rise();
      chk(sdo, 1'b1, "R5 rise keeps bit");
      set_sel(1'b0);
   endtask

   task automatic t_freeze_reselect();
      logic [FW-1:0] ea, eb;
      port_in = 2'b11; cnt_val = 20'h12345; unlock = 4'b1110;
      ea = expect_word(port_in, cnt_val, unlock);
      set_sel(1'b1);
      port_in = 2'b00; cnt_val = 20'hFEDCB; unlock = 4'b0001;
      eb = expect_word(port_in, cnt_val, unlock);
      wait_clk(3);
      read_word(ea, "R6 frozen word");
      set_sel(1'b0);
      set_sel(1'b1);
      read_word(eb, "R8 recaptured word");
      set_sel(1'b0);
   endtask

   initial begin
      t_reset();
      t_idle();
      t_order();
      t_rise_only();
      t_freeze_reselect();
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      #(CLK_PERIOD * 100000);
      total++; bad++;
      $display("FAIL watchdog got=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule